// File: doc/BRIEF.md
# Byte-Register Real-Time Tick Counter With Wake Alarm

This block keeps time for an always-on power domain. A 48-bit tick counter advances once for every cycle in which `tick_en` is high. That strobe comes from the slow oscillator domain at twice the 32768 Hz crystal rate, so the counter gains 65536 counts per second. A host reaches the block through a plain byte-wide register port. The time is set by writing six counter bytes, and it is read back as a six-byte burst. The read-back is taken from a snapshot, so a carry that happens during the burst cannot tear the value. A 32-bit alarm is compared against the upper 32 bits of the count. When the alarm is enabled and matches, the block raises a wake request level that the power controller treats as a power-up cause. The block raises no interrupt.

A control byte holds four things: the alarm enable, the oscillator-bypass and clock-output-disable controls (brought out as pins), and a monitor flag. Software can only set the monitor flag. It clears only on the power-on reset, which stands for loss of backup power, so software can tell whether the time has been set since power was lost. The register port has no back-pressure: a write or read strobe is accepted in the cycle it is high, and read data appears one cycle later and holds until the next read. Calendar conversion, the serial host bus and the oscillator itself are outside this block.

Top module: `rtc_tick_core`

## Requirements
- R1: After reset the control byte (address 0x53) reads 0x30, every counter byte reads 0x00, and `wake_req`, `osc_bypass` and `clkout_off` are low.
- R2: The live count increases by exactly one at every clock edge where `tick_en` is high, with carries across all 48 bits, and holds otherwise.
- R3: Writes to addresses 0x5A..0x5E fill a staging register and leave the live count unchanged. A write to 0x5F loads the whole count at once as {written byte, staged bytes}, with the least significant byte at 0x5A.
- R4: A read of 0x5A returns count bits 7:0 and snapshots the full count. Reads of 0x5B..0x5F return snapshot bits 15:8 up to 47:40, even if the count has moved since the snapshot. Read data is valid the cycle after `reg_rd` and holds until the next read.
- R5: The alarm bytes at 0x56..0x59 are written and read back directly. Byte 0x56 corresponds to count bits 23:16 and byte 0x59 to count bits 47:40.
- R6: With the alarm enable (control bit 2) set, `wake_req` rises at the clock edge after count bits 47:16 first equal the alarm value. It then stays high even after the count moves away.
- R7: `wake_req` falls at the clock edge of a control write that clears bit 2, or of a write to any alarm byte. It is never high while bit 2 is clear.
- R8: Control bit 0 (monitor) is set by writing a 1. Writing 0 leaves it set, and only reset clears it.
- R9: Control bits 7:1 are stored as written. Bit 1 drives `osc_bypass` and bit 3 drives `clkout_off`.
- R10: Reads of addresses other than 0x53, 0x56..0x59 and 0x5A..0x5F return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-port and counter clock |
| rst_n | input | 1 | Active-low power-on reset (backup power loss) |
| tick_en | input | 1 | One-cycle tick strobe from the oscillator domain |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| wake_req | output | 1 | Sticky alarm wake / power-up request level |
| osc_bypass | output | 1 | Oscillator bypass control (control bit 1) |
| clkout_off | output | 1 | Slow clock output buffer disable (control bit 3) |

## Verification
Several properties are checked on every cycle. The count steps by one per tick and otherwise holds, except at a top-byte load. The monitor bit never falls. The wake level never exists without the enable and holds until it is cleared. Unmapped reads return zero. Only the bench's scenarios can show the value-level behaviours: the byte order of a load, a snapshot that survives a carry, the exact cycle the wake request rises on a match and falls on an alarm rewrite, and the control byte's reset value after a second reset.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam int          BYTE_W      = 8;
  localparam int          CNT_BYTES   = 6;
  localparam int          ALM_BYTES   = 4;
  localparam logic [7:0]  CTRL_ADDR   = 8'h53;
  localparam logic [7:0]  ALM_BASE    = 8'h56;
  localparam logic [7:0]  CNT_BASE    = 8'h5A;
  localparam logic [7:0]  CTRL_RESET  = 8'h30;
  // control bit positions
  localparam int          CTL_MON     = 0;
  localparam int          CTL_BYPASS  = 1;
  localparam int          CTL_ALM_EN  = 2;
  localparam int          CTL_OUT_OFF = 3;
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter
  import rtc_tick_pkg::*;
#(
  parameter int         NBYTES = CNT_BYTES,
  parameter logic [7:0] BASE   = CNT_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  output logic [8*NBYTES-1:0]   count,
  output logic                  hit,
  output logic [7:0]            rd_byte
);
  localparam int W  = 8 * NBYTES;
  localparam int LW = W - 8;

  logic [W-1:0]      count_q;
  logic [LW-1:0]     stage_q;
  logic [LW-1:0]     snap_q;
  logic [NBYTES-1:0] sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_sel
    assign sel[b] = (addr == BASE + 8'(b));
  end
  assign hit = |sel;

  // staging bytes: all but the top one
  for (genvar b = 0; b < NBYTES - 1; b++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                stage_q[b*8 +: 8] <= '0;
      else if (wr_en && sel[b])  stage_q[b*8 +: 8] <= wdata;
    end
  end

  // live count: top-byte write loads everything, else tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count_q <= '0;
    else if (wr_en && sel[NBYTES-1])    count_q <= {wdata, stage_q};
    else if (tick_en)                   count_q <= count_q + 1'b1;
  end

  // snapshot of the upper bytes taken when the low byte is read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  snap_q <= '0;
    else if (rd_en && sel[0])    snap_q <= count_q[W-1:8];
  end

  always_comb begin
    rd_byte = '0;
    if (sel[0]) rd_byte = count_q[7:0];
    for (int b = 1; b < NBYTES; b++)
      if (sel[b]) rd_byte = snap_q[(b-1)*8 +: 8];
  end

  assign count = count_q;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_tick_pkg::*;
#(
  parameter int         NBYTES = ALM_BYTES,
  parameter logic [7:0] BASE   = ALM_BASE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  input  logic [8*NBYTES-1:0]  count_hi,
  input  logic                 alarm_en,
  input  logic                 en_off_wr,
  output logic                 hit,
  output logic [7:0]           rd_byte,
  output logic                 wake
);
  localparam int W = 8 * NBYTES;

  logic [W-1:0]      alarm_q;
  logic [NBYTES-1:0] sel;
  logic              alm_wr;
  logic              match;
  logic              wake_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign sel[b] = (addr == BASE + 8'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               alarm_q[b*8 +: 8] <= '0;
      else if (wr_en && sel[b]) alarm_q[b*8 +: 8] <= wdata;
    end
  end

  assign hit    = |sel;
  assign alm_wr = wr_en && hit;
  assign match  = (count_hi == alarm_q);

  // clear wins over set; set needs the enable already on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wake_q <= 1'b0;
    else if (alm_wr || en_off_wr)    wake_q <= 1'b0;
    else if (alarm_en && match)      wake_q <= 1'b1;
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NBYTES; b++)
      if (sel[b]) rd_byte = alarm_q[b*8 +: 8];
  end

  assign wake = wake_q;
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_tick_pkg::*;
#(
  parameter logic [7:0] ADDR  = CTRL_ADDR,
  parameter logic [7:0] RESET = CTRL_RESET
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       hit,
  output logic [7:0] ctrl,
  output logic       en_off_wr
);
  logic [7:0] ctrl_q;

  assign hit       = (addr == ADDR);
  assign en_off_wr = wr_en && hit && !wdata[CTL_ALM_EN];

  // monitor bit is set-only; the rest is plain storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctrl_q <= RESET;
    else if (wr_en && hit) ctrl_q <= {wdata[7:1], ctrl_q[CTL_MON] | wdata[CTL_MON]};
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
  import rtc_tick_pkg::*;
#(
  parameter int CNT_N = CNT_BYTES,
  parameter int ALM_N = ALM_BYTES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       wake_req,
  output logic       osc_bypass,
  output logic       clkout_off
);
  localparam int CNT_W = 8 * CNT_N;
  localparam int ALM_W = 8 * ALM_N;

  logic [CNT_W-1:0] live_count;
  logic [7:0]       ctrl_q;
  logic             ctrl_hit, cnt_hit, alm_hit;
  logic [7:0]       cnt_byte, alm_byte;
  logic             en_off_wr;
  logic [7:0]       rdata_q;
  logic [7:0]       rd_mux;

  rtc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .hit       (ctrl_hit),
    .ctrl      (ctrl_q),
    .en_off_wr (en_off_wr)
  );

  rtc_tick_counter #(.NBYTES(CNT_N)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .count   (live_count),
    .hit     (cnt_hit),
    .rd_byte (cnt_byte)
  );

  rtc_alarm_match #(.NBYTES(ALM_N)) u_alm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .count_hi  (live_count[CNT_W-1 -: ALM_W]),
    .alarm_en  (ctrl_q[CTL_ALM_EN]),
    .en_off_wr (en_off_wr),
    .hit       (alm_hit),
    .rd_byte   (alm_byte),
    .wake      (wake_req)
  );

  // sub-blocks return zero when not addressed, so OR them
  assign rd_mux = (ctrl_hit ? ctrl_q : 8'h00) | cnt_byte | alm_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata  = rdata_q;
  assign osc_bypass = ctrl_q[CTL_BYPASS];
  assign clkout_off = ctrl_q[CTL_OUT_OFF];

  logic unused_hit;
  assign unused_hit = cnt_hit ^ alm_hit;
endmodule

// File: rtl/rtc_tick_core_chk.sv
module rtc_tick_core_chk
  import rtc_tick_pkg::*;
#(
  parameter int CNT_N = CNT_BYTES,
  parameter int ALM_N = ALM_BYTES
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [7:0]         reg_addr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic               wake_req,
  input logic [8*CNT_N-1:0] count,
  input logic [7:0]         ctrl
);
  localparam int         CNT_W    = 8 * CNT_N;
  localparam logic [7:0] TOP_ADDR = CNT_BASE + 8'(CNT_N - 1);

  logic top_load, alm_touch, en_clear, unmapped;
  assign top_load  = reg_wr && (reg_addr == TOP_ADDR);
  assign alm_touch = reg_wr && (reg_addr >= ALM_BASE) && (reg_addr < ALM_BASE + 8'(ALM_N));
  assign en_clear  = reg_wr && (reg_addr == CTRL_ADDR) && !reg_wdata[CTL_ALM_EN];
  assign unmapped  = (reg_addr != CTRL_ADDR)
                   && !((reg_addr >= ALM_BASE) && (reg_addr < ALM_BASE + 8'(ALM_N)))
                   && !((reg_addr >= CNT_BASE) && (reg_addr < CNT_BASE + 8'(CNT_N)));

  // R2
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !top_load) |=> count == CNT_W'($past(count) + 1'b1));

  // R3
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !top_load) |=> $stable(count));

  // R6
  a_r6_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !alm_touch && !en_clear) |=> wake_req);

  // R7
  a_r7_wake_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ctrl[CTL_ALM_EN]);

  // R8
  a_r8_monitor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[CTL_MON] |=> ctrl[CTL_MON]);

  // R10
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && unmapped) |=> reg_rdata == 8'h00);
endmodule

bind rtc_tick_core rtc_tick_core_chk #(.CNT_N(CNT_N), .ALM_N(ALM_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .wake_req  (wake_req),
  .count     (live_count),
  .ctrl      (ctrl_q)
);

// File: tb/rtc_tick_core_bench.sv
module rtc_tick_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       wake_req, osc_bypass, clkout_off;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_tick_core u_rtc_tick_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .wake_req   (wake_req),
    .osc_bypass (osc_bypass),
    .clkout_off (clkout_off)
  );

  // entry: {op(1:read-check,0:write), req[3:0], addr, data, expect}
  localparam int NV = 39;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 4'd1,  8'h53, 8'h00, 8'h30},  // R1 control reset value
    {1'b1, 4'd1,  8'h5A, 8'h00, 8'h00},  // R1 counter reset value
    {1'b0, 4'd3,  8'h5A, 8'h11, 8'h00},
    {1'b0, 4'd3,  8'h5B, 8'h22, 8'h00},
    {1'b0, 4'd3,  8'h5C, 8'h33, 8'h00},
    {1'b0, 4'd3,  8'h5D, 8'h44, 8'h00},
    {1'b0, 4'd3,  8'h5E, 8'h55, 8'h00},
    {1'b1, 4'd3,  8'h5A, 8'h00, 8'h00},  // R3 staged bytes not live yet
    {1'b1, 4'd3,  8'h5B, 8'h00, 8'h00},
    {1'b0, 4'd3,  8'h5F, 8'h66, 8'h00},
    {1'b1, 4'd4,  8'h5A, 8'h00, 8'h11},  // R4 burst read, LSB first
    {1'b1, 4'd4,  8'h5B, 8'h00, 8'h22},
    {1'b1, 4'd4,  8'h5C, 8'h00, 8'h33},
    {1'b1, 4'd4,  8'h5D, 8'h00, 8'h44},
    {1'b1, 4'd4,  8'h5E, 8'h00, 8'h55},
    {1'b1, 4'd4,  8'h5F, 8'h00, 8'h66},
    {1'b0, 4'd5,  8'h56, 8'hAA, 8'h00},
    {1'b0, 4'd5,  8'h57, 8'hBB, 8'h00},
    {1'b0, 4'd5,  8'h58, 8'hCC, 8'h00},
    {1'b0, 4'd5,  8'h59, 8'hDD, 8'h00},
    {1'b1, 4'd5,  8'h56, 8'h00, 8'hAA},  // R5 alarm readback
    {1'b1, 4'd5,  8'h57, 8'h00, 8'hBB},
    {1'b1, 4'd5,  8'h58, 8'h00, 8'hCC},
    {1'b1, 4'd5,  8'h59, 8'h00, 8'hDD},
    {1'b0, 4'd9,  8'h53, 8'h00, 8'h00},
    {1'b1, 4'd9,  8'h53, 8'h00, 8'h00},  // R9 bits stored as written
    {1'b0, 4'd8,  8'h53, 8'h01, 8'h00},
    {1'b1, 4'd8,  8'h53, 8'h00, 8'h01},  // R8 monitor set
    {1'b0, 4'd8,  8'h53, 8'h00, 8'h00},
    {1'b1, 4'd8,  8'h53, 8'h00, 8'h01},  // R8 write of 0 ignored
    {1'b0, 4'd9,  8'h53, 8'h0A, 8'h00},
    {1'b1, 4'd9,  8'h53, 8'h00, 8'h0B},
    {1'b1, 4'd10, 8'h40, 8'h00, 8'h00},  // R10 unmapped read
    {1'b0, 4'd10, 8'h52, 8'hFF, 8'h00},
    {1'b1, 4'd10, 8'h52, 8'h00, 8'h00},
    {1'b1, 4'd10, 8'h53, 8'h00, 8'h0B},  // R10 neighbour untouched
    {1'b0, 4'd10, 8'h60, 8'h77, 8'h00},
    {1'b1, 4'd10, 8'h60, 8'h00, 8'h00},
    {1'b1, 4'd10, 8'h55, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 wake", {7'd0, wake_req}, 8'h00);
    check("R1 osc_bypass", {7'd0, osc_bypass}, 8'h00);
    check("R1 clkout_off", {7'd0, clkout_off}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        do_read(VEC[i][23:16], rv);
        check($sformatf("R%0d row %0d", VEC[i][27:24], i), rv, VEC[i][7:0]);
      end else begin
        do_write(VEC[i][23:16], VEC[i][15:8]);
      end
    end

    // R9 pins follow control bits 1 and 3 (control = 0x0B)
    check("R9 osc_bypass", {7'd0, osc_bypass}, 8'h01);
    check("R9 clkout_off", {7'd0, clkout_off}, 8'h01);
    do_write(8'h53, 8'h01);
    check("R9 osc_bypass off", {7'd0, osc_bypass}, 8'h00);
    check("R9 clkout_off off", {7'd0, clkout_off}, 8'h00);

    // R2 carry across bytes: 0xFFFF + 3 = 0x10002
    do_write(8'h5A, 8'hFF); do_write(8'h5B, 8'hFF);
    do_write(8'h5C, 8'h00); do_write(8'h5D, 8'h00);
    do_write(8'h5E, 8'h00); do_write(8'h5F, 8'h00);
    ticks(3);
    do_read(8'h5A, rv); check("R2 byte0", rv, 8'h02);
    do_read(8'h5B, rv); check("R2 byte1", rv, 8'h00);
    do_read(8'h5C, rv); check("R2 byte2", rv, 8'h01);

    // R4 snapshot survives a carry between byte reads
    do_write(8'h5A, 8'hFF); do_write(8'h5B, 8'h00); do_write(8'h5F, 8'h00);
    do_read(8'h5A, rv); check("R4 snap low", rv, 8'hFF);
    ticks(1);
    do_read(8'h5B, rv); check("R4 snap high unchanged", rv, 8'h00);
    do_read(8'h5A, rv); check("R4 new low", rv, 8'h00);
    do_read(8'h5B, rv); check("R4 new high", rv, 8'h01);

    // R6 wake on match of bits 47:16 with alarm = 1
    do_write(8'h56, 8'h01); do_write(8'h57, 8'h00);
    do_write(8'h58, 8'h00); do_write(8'h59, 8'h00);
    do_write(8'h53, 8'h05);
    do_write(8'h5A, 8'hFE); do_write(8'h5B, 8'hFF);
    do_write(8'h5C, 8'h00); do_write(8'h5F, 8'h00);
    check("R6 idle before match", {7'd0, wake_req}, 8'h00);
    ticks(2);
    check("R6 one cycle after match edge", {7'd0, wake_req}, 8'h00);
    @(negedge clk);
    check("R6 wake raised", {7'd0, wake_req}, 8'h01);
    do_write(8'h5F, 8'h00);  // count back to 0xFFFE, no match
    @(negedge clk);
    check("R6 wake sticky", {7'd0, wake_req}, 8'h01);

    // R7 clear paths
    do_write(8'h56, 8'h01);
    check("R7 cleared by alarm write", {7'd0, wake_req}, 8'h00);
    do_write(8'h53, 8'h01);
    do_write(8'h5A, 8'h00); do_write(8'h5B, 8'h00);
    do_write(8'h5C, 8'h01); do_write(8'h5F, 8'h00);
    repeat (3) @(negedge clk);
    check("R7 no wake while disabled", {7'd0, wake_req}, 8'h00);
    do_write(8'h53, 8'h05);
    check("R7 enable edge", {7'd0, wake_req}, 8'h00);
    @(negedge clk);
    check("R7 wake after enable", {7'd0, wake_req}, 8'h01);
    do_write(8'h53, 8'h01);
    check("R7 cleared by enable off", {7'd0, wake_req}, 8'h00);

    // R1 / R8 second reset clears monitor and counter
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_read(8'h53, rv); check("R8 monitor cleared by reset", rv, 8'h30);
    do_read(8'h5C, rv); check("R1 counter after reset", rv, 8'h00);
    check("R1 wake after reset", {7'd0, wake_req}, 8'h00);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end
endmodule